// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block carries out the arithmetic, logic and shift operations of a small 8-bit microcontroller datapath and works out the new status byte that goes with each result. Each issued operation takes a destination operand, a source operand (a register value or an immediate, chosen outside this block), the current status byte and an operation code. One clock later it returns the result, a result write strobe for the register file, and the complete next status byte for the status register.

Each operation class has its own flag rules. Arithmetic updates carry, zero, negative, overflow, sign and half-carry. Logic operations leave carry and half-carry unchanged. Shifts derive overflow from negative and carry. The nibble swap leaves every flag unchanged. The borrow-chained subtract and compare can only keep zero set, never set it, so that a multi-byte comparison works out correctly. The two top status bits (bit-copy and interrupt enable) always pass through unchanged.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `res_q`, `sts_q`, `res_we` and `out_valid` are all zero.
- R2: An operation issued with `in_valid` high appears on the outputs after the next rising edge, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` and `res_we` low, and `res_q` and `sts_q` keep their values.
- R3: Status bits 7 and 6 of `sts_q` always equal those of `status_in` for the issued operation. The status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5.
- R4: Add (op 0) and add-with-carry (op 1, adds C as well) give d+r(+C) mod 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow. Z and N follow the result.
- R5: Subtract (op 2) and subtract-with-carry (op 3) give d−r(−C) mod 256. C is set when r(+C) exceeds d, H is the borrow from bit 4, and V is signed overflow. For op 3, Z is set only if the result is zero and Z was already set.
- R6: Compare (op 4) and compare-with-carry (op 5) produce the flags of op 2 and op 3. They hold `res_we` low and leave `res_q` unchanged.
- R7: AND (op 6), OR (op 7) and XOR (op 8) write the bitwise result, clear V, update Z and N, and keep C and H.
- R8: One's complement (op 9) writes 255−d, forces C=1 and V=0, and keeps H.
- R9: Negate (op 10) writes 0−d. C is set when the result is nonzero, V is set when the result is 0x80, and H is set when the low nibble of d is nonzero.
- R10: Increment (op 11) sets V only for d=0x7F. Decrement (op 12) sets V only for d=0x80. Both keep C and H.
- R11: Arithmetic right shift (op 13) keeps bit 7. Logical right shift (op 14) shifts in 0. Rotate through carry (op 15) shifts the old C into bit 7. All three move the old bit 0 into C, set V=N^C, and keep H.
- R12: Nibble swap (op 16) exchanges the two 4-bit halves of d and leaves the status byte unchanged.
- R13: For every operation from op 0 to op 15, S equals N XOR V in `sts_q`.
- R14: Op codes 17 to 31 hold `res_we` low and pass `status_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for the operation on the inputs |
| op_sel | input | 5 | Operation code |
| opa | input | DW | Destination operand d |
| opb | input | DW | Source operand r (register or immediate) |
| status_in | input | 8 | Current status byte |
| res_q | output | DW | Registered result |
| res_we | output | 1 | Result write strobe |
| sts_q | output | 8 | Registered next status byte |
| out_valid | output | 1 | Outputs belong to an operation issued the cycle before |

## Verification
The hardest case to reach from the ports is the borrow-chained operations. Their zero flag depends on the incoming zero bit as well as the result, so the result must come out exactly zero while Z is both set and clear. Random operands almost never give that case. The stimulus therefore drives it directly: equal operands with carry clear, and operands one apart with carry set, each with both values of Z. It also drives the overflow boundaries of increment, decrement and negate directly. Random operations then cover the remaining operand space, including unassigned op codes and idle cycles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CP   = 5'd4,
    OP_CPC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_ASR  = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROR  = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;

  // status byte bit positions
  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_N = 2;
  localparam int SB_V = 3;
  localparam int SB_S = 4;
  localparam int SB_H = 5;
  localparam int SW   = 8;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]    op,
  input  logic [DW-1:0] d,
  input  logic [DW-1:0] r,
  input  logic [SW-1:0] st_in,
  output logic [DW-1:0] res,
  output logic [SW-1:0] st_out,
  output logic          hit,
  output logic          wr
);

  localparam int MSB = DW - 1;
  localparam int HB  = DW / 2 - 1;
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  logic          is_add, is_sub, chained, cin;
  logic [DW:0]   sum, diff;
  logic [DW-1:0] hvec;
  logic          nflag, vflag;

  always_comb begin
    is_add  = (op == OP_ADD) || (op == OP_ADC);
    is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) || (op == OP_CPC);
    chained = (op == OP_SBC) || (op == OP_CPC);
    cin     = ((op == OP_ADC) || chained) ? st_in[SB_C] : 1'b0;
    sum     = {1'b0, d} + {1'b0, r} + {{DW{1'b0}}, cin};
    diff    = {1'b0, d} - {1'b0, r} - {{DW{1'b0}}, cin};
  end

  always_comb begin
    hit    = is_add || is_sub || (op == OP_NEG) || (op == OP_INC) || (op == OP_DEC);
    wr     = hit && (op != OP_CP) && (op != OP_CPC);
    res    = d;
    st_out = st_in;
    hvec   = '0;
    vflag  = 1'b0;
    if (is_add) begin
      res          = sum[MSB:0];
      hvec         = (d & r) | (r & ~res) | (~res & d);
      vflag        = (d[MSB] & r[MSB] & ~res[MSB]) | (~d[MSB] & ~r[MSB] & res[MSB]);
      st_out[SB_C] = sum[DW];
      st_out[SB_H] = hvec[HB];
      st_out[SB_Z] = (res == '0);
    end else if (is_sub) begin
      res          = diff[MSB:0];
      hvec         = (~d & r) | (r & res) | (res & ~d);
      vflag        = (d[MSB] ^ r[MSB]) & (d[MSB] ^ res[MSB]);
      st_out[SB_C] = diff[DW];
      st_out[SB_H] = hvec[HB];
      st_out[SB_Z] = (res == '0) && (!chained || st_in[SB_Z]);
    end else if (op == OP_NEG) begin
      res          = '0 - d;
      vflag        = (res == NEG_MIN);
      st_out[SB_C] = (res != '0);
      st_out[SB_H] = res[HB] | d[HB];
      st_out[SB_Z] = (res == '0);
    end else if (op == OP_INC) begin
      res          = d + {{(DW-1){1'b0}}, 1'b1};
      vflag        = (d == POS_MAX);
      st_out[SB_Z] = (res == '0);
    end else if (op == OP_DEC) begin
      res          = d - {{(DW-1){1'b0}}, 1'b1};
      vflag        = (d == NEG_MIN);
      st_out[SB_Z] = (res == '0);
    end
    nflag = res[MSB];
    if (hit) begin
      st_out[SB_N] = nflag;
      st_out[SB_V] = vflag;
      st_out[SB_S] = nflag ^ vflag;
    end
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]    op,
  input  logic [DW-1:0] d,
  input  logic [DW-1:0] r,
  input  logic [SW-1:0] st_in,
  output logic [DW-1:0] res,
  output logic [SW-1:0] st_out,
  output logic          hit
);

  localparam int MSB = DW - 1;

  always_comb begin
    hit    = 1'b1;
    res    = d;
    st_out = st_in;
    unique case (op)
      OP_AND:  res = d & r;
      OP_OR:   res = d | r;
      OP_XOR:  res = d ^ r;
      OP_COM:  res = ~d;
      default: hit = 1'b0;
    endcase
    if (hit) begin
      if (op == OP_COM) st_out[SB_C] = 1'b1;
      st_out[SB_Z] = (res == '0);
      st_out[SB_N] = res[MSB];
      st_out[SB_V] = 1'b0;
      st_out[SB_S] = res[MSB];
    end
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]    op,
  input  logic [DW-1:0] d,
  input  logic [SW-1:0] st_in,
  output logic [DW-1:0] res,
  output logic [SW-1:0] st_out,
  output logic          hit
);

  localparam int MSB  = DW - 1;
  localparam int HALF = DW / 2;

  logic top_in, is_shift;

  always_comb begin
    is_shift = (op == OP_ASR) || (op == OP_LSR) || (op == OP_ROR);
    hit      = is_shift || (op == OP_SWAP);
    top_in   = 1'b0;
    if (op == OP_ASR) top_in = d[MSB];
    if (op == OP_ROR) top_in = st_in[SB_C];
    res    = d;
    st_out = st_in;
    if (op == OP_SWAP) begin
      res = {d[HALF-1:0], d[MSB:HALF]};
    end else if (is_shift) begin
      res          = {top_in, d[MSB:1]};
      st_out[SB_C] = d[0];
      st_out[SB_Z] = (res == '0);
      st_out[SB_N] = res[MSB];
      st_out[SB_V] = res[MSB] ^ d[0];
      st_out[SB_S] = d[0];
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [4:0]    op_sel,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [7:0]    status_in,
  output logic [DW-1:0] res_q,
  output logic          res_we,
  output logic [7:0]    sts_q,
  output logic          out_valid
);

  logic [DW-1:0] a_res, l_res, s_res, nx_res;
  logic [SW-1:0] a_st, l_st, s_st, nx_st;
  logic          a_hit, a_wr, l_hit, s_hit, nx_wr;

  alu8_arith #(.DW(DW)) u_arith (
    .op(op_sel), .d(opa), .r(opb), .st_in(status_in),
    .res(a_res), .st_out(a_st), .hit(a_hit), .wr(a_wr)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op(op_sel), .d(opa), .r(opb), .st_in(status_in),
    .res(l_res), .st_out(l_st), .hit(l_hit)
  );

  alu8_shift #(.DW(DW)) u_shift (
    .op(op_sel), .d(opa), .st_in(status_in),
    .res(s_res), .st_out(s_st), .hit(s_hit)
  );

  always_comb begin
    nx_res = opa;
    nx_st  = status_in;
    nx_wr  = 1'b0;
    if (a_hit) begin
      nx_res = a_res;
      nx_st  = a_st;
      nx_wr  = a_wr;
    end else if (l_hit) begin
      nx_res = l_res;
      nx_st  = l_st;
      nx_wr  = 1'b1;
    end else if (s_hit) begin
      nx_res = s_res;
      nx_st  = s_st;
      nx_wr  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q     <= '0;
      sts_q     <= '0;
      res_we    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      res_we    <= in_valid && nx_wr;
      if (in_valid) begin
        sts_q <= nx_st;
        if (nx_wr) res_q <= nx_res;
      end
    end
  end

endmodule

// File: rtl/alu8_sva.sv
module alu8_sva
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [4:0]    op_sel,
  input logic [DW-1:0] opa,
  input logic [7:0]    status_in,
  input logic [DW-1:0] res_q,
  input logic          res_we,
  input logic [7:0]    sts_q,
  input logic          out_valid
);

  localparam int HALF = DW / 2;

  // R2: no write strobe without an issued operation
  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !res_we);

  // R2: an idle cycle keeps the outputs
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_q) && $stable(sts_q));

  // R3: top status bits pass through
  a_r3_top_bits: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> sts_q[7:6] == $past(status_in[7:6]));

  // R6: compares never write
  a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op_sel == OP_CP || op_sel == OP_CPC)
    |-> !res_we && res_q == $past(res_q));

  // R7: logic ops keep C and H
  a_r7_keep_ch: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)
    |-> sts_q[SB_C] == $past(status_in[SB_C]) && sts_q[SB_H] == $past(status_in[SB_H])
        && !sts_q[SB_V]);

  // R12: nibble swap leaves status alone
  a_r12_swap: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op_sel == OP_SWAP)
    |-> sts_q == $past(status_in)
        && res_q == {$past(opa[HALF-1:0]), $past(opa[DW-1:HALF])});

  // R13: sign flag consistency
  a_r13_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op_sel < 5'd16) |-> sts_q[SB_S] == (sts_q[SB_N] ^ sts_q[SB_V]));

  // R14: unassigned codes do nothing
  a_r14_unassigned: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(op_sel > 5'd16) |-> !res_we && sts_q == $past(status_in));

endmodule

bind alu8_core alu8_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .opa(opa),
  .status_in(status_in), .res_q(res_q), .res_we(res_we), .sts_q(sts_q),
  .out_valid(out_valid)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] opa = '0, opb = '0, status_in = '0;
  logic [7:0] res_q, sts_q;
  logic       res_we, out_valid;

  int tests = 0;
  int fails = 0;
  int exp_res = 0;
  int exp_st = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  alu8_core #(.DW(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .opa(opa), .opb(opb),
    .status_in(status_in), .res_q(res_q), .res_we(res_we), .sts_q(sts_q),
    .out_valid(out_valid)
  );

  function automatic string req_of(int op);
    case (op)
      0, 1:          return "R4";
      2, 3:          return "R5";
      4, 5:          return "R6";
      6, 7, 8:       return "R7";
      9:             return "R8";
      10:            return "R9";
      11, 12:        return "R10";
      13, 14, 15:    return "R11";
      16:            return "R12";
      default:       return "R14";
    endcase
  endfunction

  function automatic int pack(int s, int h, int v, int n, int z, int c);
    return (s & 8'hC0) | (h << 5) | ((n ^ v) << 4) | (v << 3) | (n << 2) | (z << 1) | c;
  endfunction

  // expected behaviour written from the requirements
  task automatic model(input int op, input int a, input int b, input int s,
                       output int er, output int ew, output int es);
    int c, z, h, v, t, rr, n, cin;
    c = s & 1; z = (s >> 1) & 1; h = (s >> 5) & 1;
    er = 0; ew = 1; es = s;
    case (op)
      0, 1: begin
        cin = (op == 1) ? c : 0;
        t = a + b + cin; rr = t & 255;
        v = ((a < 128) == (b < 128)) && ((rr < 128) != (a < 128)) ? 1 : 0;
        es = pack(s, ((a & 15) + (b & 15) + cin) > 15 ? 1 : 0, v, rr >> 7,
                  rr == 0 ? 1 : 0, t > 255 ? 1 : 0);
        er = rr;
      end
      2, 3, 4, 5: begin
        cin = (op == 3 || op == 5) ? c : 0;
        t = a - b - cin; rr = t & 255;
        v = ((a < 128) != (b < 128)) && ((rr < 128) != (a < 128)) ? 1 : 0;
        es = pack(s, ((a & 15) - (b & 15) - cin) < 0 ? 1 : 0, v, rr >> 7,
                  (rr == 0 && (cin == 0 && op != 3 && op != 5 || z == 1)) ? 1 : 0,
                  t < 0 ? 1 : 0);
        er = rr; ew = (op < 4) ? 1 : 0;
      end
      6, 7, 8, 9: begin
        rr = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (op == 8) ? (a ^ b) : (255 - a);
        es = pack(s, h, 0, rr >> 7, rr == 0 ? 1 : 0, (op == 9) ? 1 : c);
        er = rr;
      end
      10: begin
        rr = (256 - a) & 255;
        es = pack(s, (a & 15) != 0 ? 1 : 0, rr == 128 ? 1 : 0, rr >> 7,
                  rr == 0 ? 1 : 0, rr != 0 ? 1 : 0);
        er = rr;
      end
      11, 12: begin
        rr = (op == 11) ? ((a + 1) & 255) : ((a + 255) & 255);
        v = (op == 11) ? (a == 127 ? 1 : 0) : (a == 128 ? 1 : 0);
        es = pack(s, h, v, rr >> 7, rr == 0 ? 1 : 0, c);
        er = rr;
      end
      13, 14, 15: begin
        rr = (a >> 1) | ((op == 13) ? (a & 128) : (op == 15) ? (c << 7) : 0);
        n = rr >> 7;
        es = pack(s, h, n ^ (a & 1), n, rr == 0 ? 1 : 0, a & 1);
        er = rr;
      end
      16: begin
        er = ((a & 15) << 4) | (a >> 4);
      end
      default: ew = 0;
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic run_op(input int op, input int a, input int b, input int s);
    int er, ew, es;
    string rq;
    model(op, a, b, s, er, ew, es);
    rq = req_of(op);
    in_valid = 1'b1; op_sel = 5'(op); opa = 8'(a); opb = 8'(b); status_in = 8'(s);
    @(negedge clk);
    if (ew != 0) exp_res = er;
    exp_st = es;
    chk(res_we == (ew != 0), rq, "write strobe", int'(res_we), ew);
    chk(int'(res_q) == exp_res, rq, "result", int'(res_q), exp_res);
    chk(int'(sts_q) == exp_st, rq, "status", int'(sts_q), exp_st);
    chk(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
  endtask

  task automatic idle_cycle();
    in_valid = 1'b0; op_sel = 5'($urandom % 17); opa = 8'($urandom); status_in = 8'($urandom);
    @(negedge clk);
    chk(!res_we && !out_valid, "R2", "idle strobes", int'({out_valid, res_we}), 0);
    chk(int'(res_q) == exp_res && int'(sts_q) == exp_st, "R2", "idle hold",
        int'({res_q, sts_q}), (exp_res << 8) | exp_st);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(res_q == 0 && sts_q == 0 && !res_we && !out_valid, "R1", "during reset",
        int'({res_q, sts_q}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(res_q == 0 && sts_q == 0 && !res_we && !out_valid, "R1", "after release",
        int'({res_q, sts_q}), 0);

    // R4 corners
    run_op(0, 8'h7F, 8'h01, 8'hC0);
    run_op(0, 8'hFF, 8'h01, 8'h00);
    run_op(1, 8'h0F, 8'h00, 8'h01);
    // R5 chained zero with Z clear and set
    run_op(3, 8'h11, 8'h10, 8'h01);
    run_op(3, 8'h11, 8'h10, 8'h03);
    run_op(2, 8'h80, 8'h01, 8'h00);
    run_op(2, 8'h00, 8'h01, 8'h02);
    // R6
    run_op(5, 8'h42, 8'h42, 8'h02);
    run_op(5, 8'h42, 8'h42, 8'h00);
    run_op(4, 8'h10, 8'h20, 8'h40);
    idle_cycle();
    // R7, R8
    run_op(6, 8'hF0, 8'h0F, 8'h21);
    run_op(8, 8'h80, 8'h01, 8'h08);
    run_op(9, 8'hFF, 8'h00, 8'h20);
    // R9
    run_op(10, 8'h80, 8'h00, 8'h00);
    run_op(10, 8'h00, 8'h00, 8'h01);
    run_op(10, 8'h10, 8'h00, 8'h00);
    // R10
    run_op(11, 8'h7F, 8'h00, 8'h21);
    run_op(11, 8'hFF, 8'h00, 8'h00);
    run_op(12, 8'h80, 8'h00, 8'h21);
    run_op(12, 8'h01, 8'h00, 8'h00);
    // R11
    run_op(13, 8'h81, 8'h00, 8'h20);
    run_op(14, 8'h01, 8'h00, 8'h00);
    run_op(15, 8'h02, 8'h00, 8'h01);
    // R12, R14
    run_op(16, 8'hA5, 8'h00, 8'h3F);
    run_op(20, 8'h12, 8'h34, 8'h5A);
    idle_cycle();

    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 10) == 0) idle_cycle();
      else run_op(int'($urandom % 20), int'($urandom % 256), int'($urandom % 256),
                  int'($urandom % 256));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule